// File: doc/BRIEF.md
# One-Hot Fuse Blow and Read Controller

This block owns the permanent configuration fuses of a programmable magnetic switch: an eight-bit switchpoint magnitude, a one-bit switchpoint sign and a five-bit output/lock register (fall time, output polarity and a device lock). An upstream key decoder, which turns supply-pin pulse patterns into strobes, tells the block which register and which mode (burn or read-back) were chosen. It then sends a strobe for each mid-level pulse and one for each long burn pulse.

The bit address is a one-hot shift register. Every selection starts it at bit 0, and each mid-level pulse moves it up one place. A burn pulse sets the single fuse under the address. Only one burn is accepted between resets, and a reset stands for a supply cycle. In read-back mode a single output shows whether the addressed fuse is set. Once the lock fuse is set, every later selection is refused.

The fuses are modelled as set-only flops. The controller reset does not clear them. Only a separate fabrication-clear input does that, and it stands for the blank state of a new die.

Top module: `fuse_blow_ctrl`

## Requirements
- R1: While `rst_n` is low and on the first sample after it is released, `rd_bit` and `blow_done` are 0 and no register is selected. `rst_n` leaves every fuse output unchanged. `fab_clr_n` low clears every fuse.
- R2: A `sel_stb` (with `sel_reg` 0 = magnitude, 1 = sign, 2 = output/lock, and `sel_mode` 0 = burn, 1 = read) selects that register and puts the address at bit 0. In read mode `rd_bit` shows the state of bit 0 on the first sample after that edge.
- R3: Each `mid_stb` on a selected register moves the one-hot address up by one bit, so n pulses address bit n.
- R4: Once the address is moved past the register's top bit, no bit is addressed. `rd_bit` is then 0, and a `blow_stb` changes no fuse and leaves `blow_done` at 0.
- R5: A `blow_stb` in burn mode with a bit addressed sets exactly that fuse. No other fuse changes. `blow_done` goes to 1, and both changes are seen on the first sample after the edge.
- R6: After one burn, `blow_done` stays 1 and every further `blow_stb` is ignored until `rst_n` is low.
- R7: A set fuse is never cleared by `rst_n`. Other bits of the same register can still be set later, and the bits add up (bit 1 then bit 0 gives code 3).
- R8: In the output/lock register, bits 1:0 drive `fall_code`, bit 2 drives `out_pol` and bit 4 drives `lock_set`. Bit 4 is reached with four `mid_stb`.
- R9: In read mode `rd_bit` is 1 for a set fuse and 0 for an intact one. It is not inverted by `out_pol`.
- R10: While `lock_set` is 1, every selection is refused in both modes. `rd_bit` stays 0 and `blow_stb` sets nothing.
- R11: A `sel_reg` of 3 selects nothing. A `blow_stb` in read mode sets nothing.
- R12: When strobes arrive in the same cycle, `sel_stb` wins over `mid_stb` and `blow_stb`, and `mid_stb` wins over `blow_stb`. The losing strobes are dropped.

Top module port order is as below.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low controller reset (supply cycle) |
| fab_clr_n | input | 1 | Synchronous active-low clear of the fuse array (blank die) |
| sel_stb | input | 1 | Register/mode selection strobe from the key decoder |
| sel_reg | input | 2 | Register code: 0 magnitude, 1 sign, 2 output/lock, 3 none |
| sel_mode | input | 1 | 0 burn, 1 read-back |
| mid_stb | input | 1 | Mid-level pulse strobe, advances the address |
| blow_stb | input | 1 | Burn pulse strobe |
| rd_bit | output | 1 | Read-back of the addressed fuse |
| blow_done | output | 1 | A burn was accepted since the last reset |
| mag_code | output | 8 | Magnitude fuses |
| mag_sign | output | 1 | Sign fuse |
| fall_code | output | 2 | Fall-time fuses |
| out_pol | output | 1 | Output polarity fuse |
| lock_set | output | 1 | Lock fuse |

## Verification
Every strobe is taken on one rising edge. The session state, the address, the fuses and `blow_done` all change on that same edge, and `rd_bit` is a combinational function of that state, so every result is due one edge after its stimulus. The bench changes inputs on the falling edge, lets exactly one rising edge pass, and samples on the next falling edge. Its expected-value model steps once per rising edge in the same order, which keeps the bench and the design in step whatever strobe mix is applied.

// File: rtl/fuse_pkg.sv
`timescale 1ns/1ps
// fuse_pkg: shared constants, register/mode codes and width helpers for the
// fuse controller. Assumes register codes match the key decoder's encoding.
package fuse_pkg;
    localparam int NUM_REGS  = 3;
    localparam int MAG_W     = 8;
    localparam int SIGN_W    = 1;
    localparam int OUT_W     = 5;
    localparam int MAX_W     = 8;
    localparam int FALL_W    = 2;
    localparam int POL_BIT   = 2;
    localparam int LOCK_BIT  = 4;

    typedef enum logic [1:0] {
        FR_MAG  = 2'd0,
        FR_SIGN = 2'd1,
        FR_OUT  = 2'd2,
        FR_NONE = 2'd3
    } fuse_reg_e;

    typedef enum logic {
        FM_BURN = 1'b0,
        FM_READ = 1'b1
    } fuse_mode_e;

    // Number of fuses in register r.
    function automatic int reg_width(input int r);
        case (r)
            0:       return MAG_W;
            1:       return SIGN_W;
            2:       return OUT_W;
            default: return 0;
        endcase
    endfunction

    // Mask of the valid address bits of register r.
    function automatic logic [MAX_W-1:0] reg_mask(input logic [1:0] r);
        logic [MAX_W-1:0] m;
        for (int i = 0; i < MAX_W; i++)
            m[i] = (i < reg_width(int'(r)));
        return m;
    endfunction
endpackage

// File: rtl/fuse_addr_shift.sv
`timescale 1ns/1ps
// fuse_addr_shift: one-hot bit address. A load puts it at bit 0; a shift moves
// it up one place, and bits outside mask are dropped, so it goes to all-zero
// (nothing addressed) past the top bit. Load has priority over shift.
module fuse_addr_shift #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         shift,
    input  logic [W-1:0] mask,
    output logic [W-1:0] addr
);
    // Address register: clear, load bit 0, or shift up within the mask.
    always_ff @(posedge clk) begin
        if (!rst_n)
            addr <= '0;
        else if (load)
            addr <= {{(W-1){1'b0}}, 1'b1};
        else if (shift)
            addr <= (addr << 1) & mask;
    end
endmodule

// File: rtl/fuse_bank.sv
`timescale 1ns/1ps
// fuse_bank: set-only storage for one fuse register. Bits can only be set;
// only the fabrication clear resets them (the controller reset does not).
module fuse_bank #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         clr_n,
    input  logic         set_en,
    input  logic [W-1:0] set_vec,
    output logic [W-1:0] bits
);
    // Sticky fuse bits: OR in the addressed bit on a burn.
    always_ff @(posedge clk) begin
        if (!clr_n)
            bits <= '0;
        else if (set_en)
            bits <= bits | set_vec;
    end
endmodule

// File: rtl/fuse_sense.sv
`timescale 1ns/1ps
// fuse_sense: read-back path. Drives 1 when enabled and the addressed fuse of
// the selected register is set. No polarity inversion is applied.
module fuse_sense #(
    parameter int NREG = 3,
    parameter int MAXW = 8
) (
    input  logic [NREG-1:0][MAXW-1:0] bank,
    input  logic [1:0]                sel,
    input  logic [MAXW-1:0]           addr,
    input  logic                      en,
    output logic                      rd
);
    // Pick the selected register and test the addressed bit.
    always_comb begin
        rd = 1'b0;
        for (int r = 0; r < NREG; r++)
            if (en && (int'(sel) == r))
                rd = |(bank[r] & addr);
    end
endmodule

// File: rtl/fuse_blow_ctrl.sv
`timescale 1ns/1ps
// fuse_blow_ctrl: burn/read-back controller for the magnitude, sign and
// output/lock fuse registers. Assumes strobes are single-cycle pulses from
// the key decoder and that rst_n models a supply cycle.
module fuse_blow_ctrl
    import fuse_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fab_clr_n,
    input  logic              sel_stb,
    input  logic [1:0]        sel_reg,
    input  logic              sel_mode,
    input  logic              mid_stb,
    input  logic              blow_stb,
    output logic              rd_bit,
    output logic              blow_done,
    output logic [MAG_W-1:0]  mag_code,
    output logic              mag_sign,
    output logic [FALL_W-1:0] fall_code,
    output logic              out_pol,
    output logic              lock_set
);
    logic                             act_q;
    fuse_reg_e                        reg_q;
    fuse_mode_e                       mode_q;
    logic                             done_q;
    logic [MAX_W-1:0]                 addr_q;
    logic [NUM_REGS-1:0][MAX_W-1:0]   bank_w;
    logic                             lock_now;
    logic                             sel_ok;
    logic                             burn_go;

    assign lock_now = bank_w[FR_OUT][LOCK_BIT];
    assign sel_ok   = sel_stb && !lock_now && (sel_reg != FR_NONE);
    assign burn_go  = blow_stb && !sel_stb && !mid_stb && act_q &&
                      (mode_q == FM_BURN) && !done_q && (|addr_q);

    // Session state: the selected register and mode, plus the one-burn flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q  <= 1'b0;
            reg_q  <= FR_NONE;
            mode_q <= FM_BURN;
            done_q <= 1'b0;
        end else if (sel_stb) begin
            act_q  <= sel_ok;
            reg_q  <= fuse_reg_e'(sel_reg);
            mode_q <= fuse_mode_e'(sel_mode);
        end else if (burn_go) begin
            done_q <= 1'b1;
        end
    end

    fuse_addr_shift #(.W(MAX_W)) u_addr (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (sel_ok),
        .shift (mid_stb && !sel_stb && act_q),
        .mask  (reg_mask(reg_q)),
        .addr  (addr_q)
    );

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_bank
        localparam int W = reg_width(g);
        fuse_bank #(.W(W)) u_bank (
            .clk     (clk),
            .clr_n   (fab_clr_n),
            .set_en  (burn_go && (reg_q == fuse_reg_e'(2'(g)))),
            .set_vec (addr_q[W-1:0]),
            .bits    (bank_w[g][W-1:0])
        );
        if (W < MAX_W) begin : g_pad
            assign bank_w[g][MAX_W-1:W] = '0;
        end
    end

    fuse_sense #(.NREG(NUM_REGS), .MAXW(MAX_W)) u_sense (
        .bank (bank_w),
        .sel  (reg_q),
        .addr (addr_q),
        .en   (act_q && (mode_q == FM_READ)),
        .rd   (rd_bit)
    );

    assign blow_done = done_q;
    assign mag_code  = bank_w[FR_MAG][MAG_W-1:0];
    assign mag_sign  = bank_w[FR_SIGN][0];
    assign fall_code = bank_w[FR_OUT][FALL_W-1:0];
    assign out_pol   = bank_w[FR_OUT][POL_BIT];
    assign lock_set  = lock_now;
endmodule

// File: rtl/fuse_blow_ctrl_chk.sv
`timescale 1ns/1ps
// fuse_blow_ctrl_chk: temporal checks on the controller ports, attached by bind.
module fuse_blow_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       fab_clr_n,
    input logic       rd_bit,
    input logic       blow_done,
    input logic [7:0] mag_code,
    input logic       mag_sign,
    input logic [1:0] fall_code,
    input logic       out_pol,
    input logic       lock_set
);
    logic [12:0] all_f;
    logic        armed = 1'b0;

    assign all_f = {mag_code, mag_sign, fall_code, out_pol, lock_set};

    // Arm the fuse checks once the fuse array has been cleared at least once.
    always @(posedge clk)
        if (!fab_clr_n) armed <= 1'b1;

    // R7: a set fuse never clears while the fabrication clear is high.
    a_r7_fuse_sticky: assert property (@(posedge clk) disable iff (!fab_clr_n)
        armed |=> ((all_f & $past(all_f)) == $past(all_f)));

    // R5: at most one fuse changes per cycle.
    a_r5_one_fuse_per_burn: assert property (@(posedge clk) disable iff (!fab_clr_n)
        armed |=> ($countones(all_f ^ $past(all_f)) <= 1));

    // R6: the burn flag holds until reset.
    a_r6_done_holds: assert property (@(posedge clk) disable iff (!rst_n)
        blow_done |=> blow_done);

    // R6: no fuse changes once a burn has been taken.
    a_r6_frozen_after_burn: assert property (@(posedge clk) disable iff (!rst_n || !fab_clr_n)
        blow_done |=> $stable(all_f));

    // R10: a locked part never reads back a set bit.
    a_r10_locked_no_read: assert property (@(posedge clk) disable iff (!rst_n)
        lock_set |-> !rd_bit);
endmodule

bind fuse_blow_ctrl fuse_blow_ctrl_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .fab_clr_n (fab_clr_n),
    .rd_bit    (rd_bit),
    .blow_done (blow_done),
    .mag_code  (mag_code),
    .mag_sign  (mag_sign),
    .fall_code (fall_code),
    .out_pol   (out_pol),
    .lock_set  (lock_set)
);

// File: tb/sim_fuse_blow_ctrl.sv
`timescale 1ns/1ps
// sim_fuse_blow_ctrl: directed corners plus seeded random strobes, compared
// each cycle against a bench model built from the requirements.
module sim_fuse_blow_ctrl;
    logic       clk = 1'b0;
    logic       rst_n, fab_clr_n, sel_stb, sel_mode, mid_stb, blow_stb;
    logic [1:0] sel_reg;
    logic       rd_bit, blow_done, mag_sign, out_pol, lock_set;
    logic [7:0] mag_code;
    logic [1:0] fall_code;

    int ncmp = 0;
    int nbad = 0;

    // Bench model state.
    logic [7:0] mf [3];
    bit         m_act, m_mode, m_done;
    int         m_reg, m_idx;

    always #5 clk = ~clk;

    fuse_blow_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .fab_clr_n(fab_clr_n),
        .sel_stb(sel_stb), .sel_reg(sel_reg), .sel_mode(sel_mode),
        .mid_stb(mid_stb), .blow_stb(blow_stb),
        .rd_bit(rd_bit), .blow_done(blow_done), .mag_code(mag_code),
        .mag_sign(mag_sign), .fall_code(fall_code), .out_pol(out_pol),
        .lock_set(lock_set)
    );

    function automatic int wdt(input int r);
        return (r == 0) ? 8 : (r == 1) ? 1 : (r == 2) ? 5 : 0;
    endfunction

    function automatic bit exp_rd();
        if (!m_act || !m_mode || m_idx >= wdt(m_reg)) return 1'b0;
        return mf[m_reg][m_idx];
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        ncmp++;
        if (act !== exp) begin
            nbad++;
            $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
        end
    endtask

    task automatic cmp_all(input string req);
        chk(req, "rd_bit", 32'(rd_bit), 32'(exp_rd()));
        chk(req, "blow_done", 32'(blow_done), 32'(m_done));
        chk(req, "fuses", {19'd0, mag_code, mag_sign, fall_code, out_pol, lock_set},
            {19'd0, mf[0], mf[1][0], mf[2][1:0], mf[2][2], mf[2][4]});
    endtask

    // Model step for one rising edge, using the pre-edge state.
    task automatic step_model(input bit s, input int r, input bit m,
                              input bit mid, input bit bl);
        if (s) begin
            m_act = !mf[2][4] && (r != 3);
            m_reg = r; m_mode = m; m_idx = 0;
        end else if (mid) begin
            if (m_act && m_idx < wdt(m_reg)) m_idx++;
        end else if (bl) begin
            if (m_act && !m_mode && !m_done && m_idx < wdt(m_reg)) begin
                mf[m_reg][m_idx] = 1'b1;
                m_done = 1'b1;
            end
        end
    endtask

    task automatic cyc(input string req, input bit s, input int r, input bit m,
                       input bit mid, input bit bl);
        sel_stb = s; sel_reg = 2'(r); sel_mode = m; mid_stb = mid; blow_stb = bl;
        @(posedge clk);
        step_model(s, r, m, mid, bl);
        @(negedge clk);
        sel_stb = 0; mid_stb = 0; blow_stb = 0;
        cmp_all(req);
    endtask

    task automatic do_rst(input string req);
        sel_stb = 0; mid_stb = 0; blow_stb = 0;
        rst_n = 0;
        @(posedge clk); @(posedge clk);
        m_act = 0; m_done = 0; m_idx = 0;
        @(negedge clk);
        cmp_all(req);
        rst_n = 1;
    endtask

    task automatic sel(input string req, input int r, input bit m);
        cyc(req, 1, r, m, 0, 0);
    endtask
    task automatic mids(input string req, input int n);
        for (int i = 0; i < n; i++) cyc(req, 0, 0, 0, 1, 0);
    endtask
    task automatic burn(input string req);
        cyc(req, 0, 0, 0, 0, 1);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", ncmp, nbad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        nbad++;
        $display("FAIL R1 watchdog act=running exp=finished");
        summary();
    end

    initial begin
        void'($urandom(32'd1729));
        rst_n = 0; fab_clr_n = 0; sel_stb = 0; sel_reg = 0; sel_mode = 0;
        mid_stb = 0; blow_stb = 0;
        for (int i = 0; i < 3; i++) mf[i] = '0;
        m_act = 0; m_done = 0; m_idx = 0; m_reg = 3; m_mode = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        cmp_all("R1");
        fab_clr_n = 1; rst_n = 1;

        // R2 / R3: read a blank magnitude register.
        sel("R2", 0, 1);
        chk("R2", "rd blank", 32'(rd_bit), 0);
        mids("R3", 3);

        // R5: burn magnitude bit 2, R6: a second burn is ignored.
        do_rst("R1");
        sel("R5", 0, 0); mids("R3", 2); burn("R5");
        chk("R5", "mag", 32'(mag_code), 4);
        chk("R5", "done", 32'(blow_done), 1);
        mids("R6", 1); burn("R6");
        chk("R6", "mag after 2nd burn", 32'(mag_code), 4);

        // R7: survives reset, bits accumulate.
        do_rst("R7");
        chk("R7", "mag kept", 32'(mag_code), 4);
        sel("R7", 0, 0); burn("R7");
        chk("R7", "mag accum", 32'(mag_code), 5);

        // R2 / R3 / R4: read back across the register and past the top.
        do_rst("R1");
        sel("R2", 0, 1);
        chk("R2", "rd bit0", 32'(rd_bit), 1);
        mids("R3", 1);
        chk("R3", "rd bit1", 32'(rd_bit), 0);
        mids("R3", 1);
        chk("R3", "rd bit2", 32'(rd_bit), 1);
        mids("R4", 6);
        chk("R4", "rd past top", 32'(rd_bit), 0);

        // R4: burn past the top of the sign register does nothing.
        do_rst("R1");
        sel("R4", 1, 0); mids("R4", 1); burn("R4");
        chk("R4", "sign", 32'(mag_sign), 0);
        chk("R4", "done", 32'(blow_done), 0);

        // R11: register code 3 and a burn in read mode.
        sel("R11", 3, 0); burn("R11");
        chk("R11", "done", 32'(blow_done), 0);
        sel("R11", 0, 1); mids("R11", 1); burn("R11");
        chk("R11", "mag", 32'(mag_code), 5);

        // R12: strobe priority.
        do_rst("R1");
        cyc("R12", 1, 0, 0, 1, 1);
        chk("R12", "done after sel+mid+burn", 32'(blow_done), 0);
        cyc("R12", 0, 0, 0, 1, 1);
        chk("R12", "mag after mid+burn", 32'(mag_code), 5);
        burn("R12");
        chk("R12", "mag bit1 burned", 32'(mag_code), 7);

        // R8 / R9: polarity fuse, read-back not inverted, fall bit.
        do_rst("R1");
        sel("R8", 2, 0); mids("R8", 2); burn("R8");
        chk("R8", "out_pol", 32'(out_pol), 1);
        chk("R8", "fall", 32'(fall_code), 0);
        sel("R9", 2, 1);
        chk("R9", "rd intact bit0", 32'(rd_bit), 0);
        mids("R9", 2);
        chk("R9", "rd set bit2", 32'(rd_bit), 1);
        do_rst("R1");
        sel("R8", 2, 0); burn("R8");
        chk("R8", "fall", 32'(fall_code), 1);

        // Seeded random strobes against the model.
        do_rst("R1");
        for (int i = 0; i < 400; i++) begin
            int k;
            k = int'($urandom % 16);
            if (k == 15 && ($urandom % 4) == 0)
                do_rst("R1");
            else
                cyc("R5 random", k < 3, int'($urandom % 4), bit'($urandom % 2),
                    (k >= 3 && k < 10) || (($urandom % 8) == 0), k >= 10 && k < 13);
        end

        // R8 / R10: set the lock, then every selection is refused.
        do_rst("R1");
        sel("R8", 2, 0); mids("R8", 4); burn("R8");
        chk("R8", "lock", 32'(lock_set), 1);
        do_rst("R10");
        sel("R10", 0, 1);
        chk("R10", "rd locked", 32'(rd_bit), 0);
        sel("R10", 1, 0); burn("R10");
        chk("R10", "done locked", 32'(blow_done), 0);
        chk("R10", "sign locked", 32'(mag_sign), 32'(mf[1][0]));

        summary();
    end
endmodule